// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block drives a group of derived clocks from one internal fast clock and gates each of them cleanly. A free-running phase counter produces three raw clock phases: a CPU phase, a graphics-port phase at twice the PCI rate, and a PCI phase. Each gated output is a registered copy of its raw phase, qualified by a per-output "live" state that may change only at the instant its raw phase falls. Neither stopping nor restarting can therefore cut a high pulse short or create a runt.

Three active-low asynchronous controls act on the outputs: a CPU stop, a PCI stop and a power-down. Each passes through a two-flop synchronizer before use. Per-output enable bits come from a register file in the fast-clock domain and act through the same falling-edge gate. The CPU outputs are true/complement pairs. When stopped or disabled, the true side parks low and the complement side parks high. On power-down, every output, including the complements, parks low and the stop controls no longer matter. One PCI output runs free of the PCI stop. The graphics-port outputs also ignore the PCI stop.

Top module: `clkstop_ctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every output (including `cpu_c`) is 0.
- R2: Each of `cpu_stop_n`, `pci_stop_n` and `pwr_dn_n` passes through two fast-clock flip-flops before it can affect any output.
- R3: A phase index starts at 0 after reset and counts modulo 2*PCI_HALF. A raw phase with half-period H is high when floor(index/H) is even. A gated output is high only while its raw phase is high, and every high pulse lasts exactly H fast cycles.
- R4: When the synchronized CPU stop is 0 and power is up, each `cpu_t` bit parks at 0 and each `cpu_c` bit parks at 1. The decision is taken at the next falling boundary of the CPU phase, which is well within 4 CPU periods.
- R5: While a CPU pair runs, `cpu_c` is the inverse of `cpu_t`; the two are never high together.
- R6: The synchronized PCI stop parks every `pci_q` bit low from the next falling PCI boundary. `pci_free` and `agp_q` ignore the PCI stop.
- R7: While the synchronized power-down is 0, each output is parked low from the next falling boundary of its own phase; `cpu_c` goes low at the CPU falling boundary. The stop inputs have no effect during power-down.
- R8: An enable bit of 1 lets its output run and 0 parks it. The bit is sampled only at the falling boundary of that output's phase. A disabled CPU pair parks as in R4.
- R9: After a stop, disable or power-down is released, the first high pulse starts at a rising edge of the raw phase and has full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous CPU stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI stop, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down, active low |
| cpu_en | input | N_CPU | Per-pair CPU enables, 1 = run |
| pci_en | input | N_PCI | Per-output stoppable PCI enables, 1 = run |
| agp_en | input | N_AGP | Per-output graphics-port enables, 1 = run |
| cpu_t | output | N_CPU | CPU true clocks |
| cpu_c | output | N_CPU | CPU complement clocks |
| pci_q | output | N_PCI | Stoppable PCI clocks |
| pci_free | output | 1 | Free-running PCI clock |
| agp_q | output | N_AGP | Graphics-port clocks (twice PCI rate) |

## Verification
The bench uses the default parameter values: three CPU pairs, seven stoppable PCI outputs and two graphics-port outputs. The CPU half-period is 1, the graphics-port half-period is 2 and the PCI half-period is 4, so all three phases share an 8-cycle counter. Random hold times of 1 to 25 cycles therefore land control changes at every alignment against each falling boundary. One-cycle pulses on the stop and power-down inputs exercise the cases where the synchronized value changes between two boundaries. With the CPU half-period of 1, a single stop pulse can either catch a boundary or miss it entirely.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  localparam int DOM_CPU = 0;
  localparam int DOM_AGP = 1;
  localparam int DOM_PCI = 2;
  localparam int DOM_N   = 3;

  // Raw phase level at a given phase index for a half-period
  function automatic logic lvl_hi(input int unsigned idx, input int unsigned half);
    return ((idx / half) % 2) == 0;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  // Reset to 0: every control starts asserted, so outputs start parked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase
  import clkstop_pkg::*;
#(
  parameter int unsigned CPU_HALF = 1,
  parameter int unsigned AGP_HALF = 2,
  parameter int unsigned PCI_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [DOM_N-1:0] dom_raw,
  output logic [DOM_N-1:0] dom_nxt,
  output logic [DOM_N-1:0] dom_fall
);
  localparam int unsigned PERIOD = 2 * PCI_HALF;
  localparam int          CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int unsigned HALF_TAB [DOM_N] = '{CPU_HALF, AGP_HALF, PCI_HALF};

  logic [CW-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  for (genvar g = 0; g < DOM_N; g++) begin : g_dom
    assign dom_raw[g]  = lvl_hi(32'(cnt_q), HALF_TAB[g]);
    assign dom_nxt[g]  = lvl_hi(32'(cnt_nxt), HALF_TAB[g]);
    assign dom_fall[g] = dom_raw[g] & ~dom_nxt[g];
  end
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic ph_nxt,
  input  logic allow,
  output logic clk_q,
  output logic live_q
);
  // live_q moves only where the raw phase drops, so a pulse is never cut
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      clk_q <= live_q & ph_nxt;
      if (fall) live_q <= allow;
    end
  end
endmodule

// File: rtl/clkstop_ctl.sv
module clkstop_ctl
  import clkstop_pkg::*;
#(
  parameter int          N_CPU    = 3,
  parameter int          N_PCI    = 7,
  parameter int          N_AGP    = 2,
  parameter int unsigned CPU_HALF = 1,
  parameter int unsigned AGP_HALF = 2,
  parameter int unsigned PCI_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_dn_n,
  input  logic [N_CPU-1:0] cpu_en,
  input  logic [N_PCI-1:0] pci_en,
  input  logic [N_AGP-1:0] agp_en,
  output logic [N_CPU-1:0] cpu_t,
  output logic [N_CPU-1:0] cpu_c,
  output logic [N_PCI-1:0] pci_q,
  output logic             pci_free,
  output logic [N_AGP-1:0] agp_q
);
  // Synchronized controls, 1 = run
  logic [2:0] ctl_s;
  logic       cpu_run_s, pci_run_s, pd_s;

  clkstop_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({pwr_dn_n, pci_stop_n, cpu_stop_n}),
    .q    (ctl_s)
  );

  assign cpu_run_s = ctl_s[0];
  assign pci_run_s = ctl_s[1];
  assign pd_s      = ctl_s[2];

  // Phase generation
  logic [DOM_N-1:0] dom_raw, dom_nxt, dom_fall;

  clkstop_phase #(
    .CPU_HALF(CPU_HALF),
    .AGP_HALF(AGP_HALF),
    .PCI_HALF(PCI_HALF)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .dom_raw (dom_raw),
    .dom_nxt (dom_nxt),
    .dom_fall(dom_fall)
  );

  logic [N_CPU-1:0] cpu_live;
  logic [N_PCI-1:0] pci_live;
  logic [N_AGP-1:0] agp_live;
  logic             free_live;

  // CPU true side
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    clkstop_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .fall  (dom_fall[DOM_CPU]),
      .ph_nxt(dom_nxt[DOM_CPU]),
      .allow (pd_s & cpu_run_s & cpu_en[i]),
      .clk_q (cpu_t[i]),
      .live_q(cpu_live[i])
    );
  end

  // CPU complement side: power-down state tracked at the CPU falling boundary
  logic cpu_down_q, cpu_down_nxt;
  assign cpu_down_nxt = dom_fall[DOM_CPU] ? ~pd_s : cpu_down_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_down_q <= 1'b1;
    else        cpu_down_q <= cpu_down_nxt;
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpuc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cpu_c[i] <= 1'b0;
      else if (cpu_down_nxt) cpu_c[i] <= 1'b0;
      else if (cpu_live[i])  cpu_c[i] <= ~dom_nxt[DOM_CPU];
      else                   cpu_c[i] <= 1'b1;
    end
  end

  // Stoppable PCI outputs
  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    clkstop_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .fall  (dom_fall[DOM_PCI]),
      .ph_nxt(dom_nxt[DOM_PCI]),
      .allow (pd_s & pci_run_s & pci_en[i]),
      .clk_q (pci_q[i]),
      .live_q(pci_live[i])
    );
  end

  // Free-running PCI output: power-down only
  clkstop_gate u_free (
    .clk   (clk),
    .rst_n (rst_n),
    .fall  (dom_fall[DOM_PCI]),
    .ph_nxt(dom_nxt[DOM_PCI]),
    .allow (pd_s),
    .clk_q (pci_free),
    .live_q(free_live)
  );

  // Graphics-port outputs: power-down and enable only
  for (genvar i = 0; i < N_AGP; i++) begin : g_agp
    clkstop_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .fall  (dom_fall[DOM_AGP]),
      .ph_nxt(dom_nxt[DOM_AGP]),
      .allow (pd_s & agp_en[i]),
      .clk_q (agp_q[i]),
      .live_q(agp_live[i])
    );
  end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk
  import clkstop_pkg::*;
#(
  parameter int          N_CPU    = 3,
  parameter int          N_PCI    = 7,
  parameter int          N_AGP    = 2,
  parameter int unsigned CPU_HALF = 1,
  parameter int unsigned PCI_HALF = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DOM_N-1:0] dom_raw,
  input logic [DOM_N-1:0] dom_fall,
  input logic [N_CPU-1:0] cpu_t,
  input logic [N_CPU-1:0] cpu_c,
  input logic [N_PCI-1:0] pci_q,
  input logic             pci_free,
  input logic [N_AGP-1:0] agp_q,
  input logic [N_CPU-1:0] cpu_live,
  input logic [N_PCI-1:0] pci_live,
  input logic [N_AGP-1:0] agp_live,
  input logic             free_live,
  input logic             cpu_run_s,
  input logic             pd_s
);
  localparam int unsigned CPU_LIM = 4 * CPU_HALF + 2;
  localparam int unsigned PD_LIM  = 2 * PCI_HALF + 2;
  localparam int          SW      = $clog2(CPU_LIM + PD_LIM + 1) + 1;

  logic [SW-1:0] stop_cnt_q, pd_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_cnt_q <= '0;
      pd_cnt_q   <= '0;
    end else begin
      if (cpu_run_s)                           stop_cnt_q <= '0;
      else if (stop_cnt_q < SW'(CPU_LIM + 1))  stop_cnt_q <= stop_cnt_q + 1'b1;
      if (pd_s)                                pd_cnt_q <= '0;
      else if (pd_cnt_q < SW'(PD_LIM + 1))     pd_cnt_q <= pd_cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    assert_pci_in_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pci_q[i] |-> dom_raw[DOM_PCI]);
    assert_pci_full_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pci_q[i]) |-> $rose(dom_raw[DOM_PCI]));
    assert_pci_full_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pci_q[i]) |-> $fell(dom_raw[DOM_PCI]));
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assert_cpu_in_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_t[i] |-> dom_raw[DOM_CPU]);
    assert_cpu_full_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_t[i]) |-> $rose(dom_raw[DOM_CPU]));
    assert_pair_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_t[i] && cpu_c[i]));
  end

  for (genvar i = 0; i < N_AGP; i++) begin : g_agp
    assert_agp_full_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(agp_q[i]) |-> $rose(dom_raw[DOM_AGP]));
  end

  assert_cpu_live_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_fall[DOM_CPU] |=> $stable(cpu_live));
  assert_pci_live_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_fall[DOM_PCI] |=> ($stable(pci_live) && $stable(free_live)));
  assert_agp_live_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_fall[DOM_AGP] |=> $stable(agp_live));

  assert_cpu_stop_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cnt_q >= SW'(CPU_LIM)) |-> (cpu_t == '0));
  assert_pd_all_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_cnt_q >= SW'(PD_LIM)) |->
      (cpu_t == '0 && cpu_c == '0 && pci_q == '0 && !pci_free && agp_q == '0));
endmodule

bind clkstop_ctl clkstop_chk #(
  .N_CPU   (N_CPU),
  .N_PCI   (N_PCI),
  .N_AGP   (N_AGP),
  .CPU_HALF(CPU_HALF),
  .PCI_HALF(PCI_HALF)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dom_raw  (dom_raw),
  .dom_fall (dom_fall),
  .cpu_t    (cpu_t),
  .cpu_c    (cpu_c),
  .pci_q    (pci_q),
  .pci_free (pci_free),
  .agp_q    (agp_q),
  .cpu_live (cpu_live),
  .pci_live (pci_live),
  .agp_live (agp_live),
  .free_live(free_live),
  .cpu_run_s(cpu_run_s),
  .pd_s     (pd_s)
);

// File: tb/sim_clkstop_ctl.sv
`timescale 1ns/1ps
module sim_clkstop_ctl;
  localparam int N_CPU = 3, N_PCI = 7, N_AGP = 2;
  localparam int CPU_HALF = 1, AGP_HALF = 2, PCI_HALF = 4;
  localparam int P = 2 * PCI_HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
  logic [N_CPU-1:0] cpu_en = '1;
  logic [N_PCI-1:0] pci_en = '1;
  logic [N_AGP-1:0] agp_en = '1;
  logic [N_CPU-1:0] cpu_t, cpu_c;
  logic [N_PCI-1:0] pci_q;
  logic             pci_free;
  logic [N_AGP-1:0] agp_q;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkstop_ctl #(
    .N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP),
    .CPU_HALF(CPU_HALF), .AGP_HALF(AGP_HALF), .PCI_HALF(PCI_HALF)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
    .cpu_en(cpu_en), .pci_en(pci_en), .agp_en(agp_en),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .pci_q(pci_q),
    .pci_free(pci_free), .agp_q(agp_q)
  );

  function automatic bit lvl(input int idx, input int half);
    return ((idx / half) % 2) == 0;
  endfunction

  // Cycle model built from the requirements
  int mp;
  bit [2:0] m1, m2;  // R2: two-stage view of {pd, pci stop, cpu stop}
  bit [N_CPU-1:0] mct, mcc, mcl;
  bit [N_PCI-1:0] mpq, mpl;
  bit [N_AGP-1:0] maq, mal;
  bit mf, mfl, mdown;

  always @(posedge clk) begin
    if (!rst_n) begin
      mp = 0; m1 = '0; m2 = '0;
      mct = '0; mcc = '0; mcl = '0; mpq = '0; mpl = '0;
      maq = '0; mal = '0; mf = 0; mfl = 0; mdown = 1;
    end else begin
      int pn;
      bit fc, fa, fpc, nc, na, np, dn;
      pn  = (mp + 1) % P;
      nc  = lvl(pn, CPU_HALF);
      na  = lvl(pn, AGP_HALF);
      np  = lvl(pn, PCI_HALF);
      fc  = lvl(mp, CPU_HALF) && !nc;
      fa  = lvl(mp, AGP_HALF) && !na;
      fpc = lvl(mp, PCI_HALF) && !np;
      dn  = fc ? !m2[2] : mdown;
      for (int i = 0; i < N_CPU; i++) begin
        mct[i] = mcl[i] & nc;
        mcc[i] = dn ? 1'b0 : (mcl[i] ? !nc : 1'b1);
        if (fc) mcl[i] = m2[2] & m2[0] & cpu_en[i];
      end
      mdown = dn;
      for (int i = 0; i < N_PCI; i++) begin
        mpq[i] = mpl[i] & np;
        if (fpc) mpl[i] = m2[2] & m2[1] & pci_en[i];
      end
      mf = mfl & np;
      if (fpc) mfl = m2[2];
      for (int i = 0; i < N_AGP; i++) begin
        maq[i] = mal[i] & na;
        if (fa) mal[i] = m2[2] & agp_en[i];
      end
      m2 = m1;
      m1 = {pwr_dn_n, pci_stop_n, cpu_stop_n};
      mp = pn;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 40) $display("FAIL %s actual=%h expected=%h t=%0t", what, act, exp, $time);
    end
  endtask

  int cw [N_CPU];
  int pw [N_PCI];
  int aw [N_AGP];
  int fw = 0;

  // Pulse width tracking (R3): every completed high pulse has full width
  task automatic track_widths();
    for (int i = 0; i < N_CPU; i++) begin
      if (cpu_t[i]) cw[i]++;
      else if (cw[i] > 0) begin chk(cw[i] == CPU_HALF, "R3 cpu_t width", cw[i], CPU_HALF); cw[i] = 0; end
    end
    for (int i = 0; i < N_PCI; i++) begin
      if (pci_q[i]) pw[i]++;
      else if (pw[i] > 0) begin chk(pw[i] == PCI_HALF, "R3 pci_q width", pw[i], PCI_HALF); pw[i] = 0; end
    end
    for (int i = 0; i < N_AGP; i++) begin
      if (agp_q[i]) aw[i]++;
      else if (aw[i] > 0) begin chk(aw[i] == AGP_HALF, "R3 agp_q width", aw[i], AGP_HALF); aw[i] = 0; end
    end
    if (pci_free) fw++;
    else if (fw > 0) begin chk(fw == PCI_HALF, "R3 pci_free width", fw, PCI_HALF); fw = 0; end
  endtask

  task automatic compare_model();
    chk(cpu_t === mct, "R2/R4/R8/R9 cpu_t", 32'(cpu_t), 32'(mct));
    chk(cpu_c === mcc, "R5/R7 cpu_c", 32'(cpu_c), 32'(mcc));
    chk(pci_q === mpq, "R6 pci_q", 32'(pci_q), 32'(mpq));
    chk(pci_free === mf, "R6/R7 pci_free", 32'(pci_free), 32'(mf));
    chk(agp_q === maq, "R6/R8 agp_q", 32'(agp_q), 32'(maq));
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      compare_model();
      track_widths();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit seen_hi, seen_lo, seen_ahi;
    void'($urandom(32'd2024));
    for (int i = 0; i < N_CPU; i++) cw[i] = 0;
    for (int i = 0; i < N_PCI; i++) pw[i] = 0;
    for (int i = 0; i < N_AGP; i++) aw[i] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk({cpu_t, cpu_c, pci_q, pci_free, agp_q} == '0, "R1 reset outputs", 32'({cpu_t, cpu_c, pci_q, pci_free, agp_q}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cpu_t, cpu_c, pci_q, pci_free, agp_q} == '0, "R1 first cycle", 32'({cpu_t, cpu_c, pci_q, pci_free, agp_q}), 0);
    compare_model();
    step(40);

    // R4: CPU stop parks true low, complement high
    cpu_stop_n = 1'b0;
    step(20);
    chk(cpu_t == '0, "R4 cpu_t parked", 32'(cpu_t), 0);
    chk(cpu_c == '1, "R4 cpu_c parked", 32'(cpu_c), 32'({N_CPU{1'b1}}));
    cpu_stop_n = 1'b1;
    step(20);

    // R6: PCI stop leaves free-running and graphics-port outputs alone
    pci_stop_n = 1'b0;
    step(20);
    chk(pci_q == '0, "R6 pci_q parked", 32'(pci_q), 0);
    seen_hi = 0; seen_lo = 0; seen_ahi = 0;
    for (int k = 0; k < 16; k++) begin
      step(1);
      if (pci_free) seen_hi = 1; else seen_lo = 1;
      if (agp_q[0]) seen_ahi = 1;
    end
    chk(seen_hi && seen_lo, "R6 pci_free toggles", {seen_hi, seen_lo}, 2'b11);
    chk(seen_ahi, "R6 agp toggles", seen_ahi, 1);
    pci_stop_n = 1'b1;
    step(20);

    // R7: power-down, stop inputs don't care
    pwr_dn_n = 1'b0;
    step(20);
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
    step(5);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    step(5);
    chk({cpu_t, cpu_c, pci_q, pci_free, agp_q} == '0, "R7 all low", 32'({cpu_t, cpu_c, pci_q, pci_free, agp_q}), 0);
    pwr_dn_n = 1'b1;
    step(20);

    // R8: per-output enables
    cpu_en = 3'b010; pci_en = 7'b1010101; agp_en = 2'b01;
    step(20);
    seen_hi = 0;
    for (int k = 0; k < 16; k++) begin
      step(1);
      if ((cpu_t & ~cpu_en) != '0 || (pci_q & ~pci_en) != '0 || (agp_q & ~agp_en) != '0) seen_hi = 1;
    end
    chk(!seen_hi, "R8 disabled stay low", seen_hi, 0);
    chk(cpu_c[0] && cpu_c[2], "R8 disabled pair complement high", 32'(cpu_c), 32'b101);
    cpu_en = '1; pci_en = '1; agp_en = '1;
    step(20);

    // Short one-cycle pulses on the controls (R2, R9)
    for (int k = 0; k < 8; k++) begin
      cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
      step(1);
      cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
      step(k + 1);
    end

    // Constrained random segments
    for (int s = 0; s < 300; s++) begin
      cpu_stop_n = ($urandom % 10) >= 3;
      pci_stop_n = ($urandom % 10) >= 3;
      pwr_dn_n   = ($urandom % 10) >= 2;
      if (($urandom % 4) == 0) begin
        cpu_en = N_CPU'($urandom);
        pci_en = N_PCI'($urandom);
        agp_en = N_AGP'($urandom);
      end
      step(1 + ($urandom % 25));
    end

    finish_run();
  end
endmodule